// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This block sits between a 32-bit processor pipeline and a byte-addressed data memory that is one word wide and has a write enable for each byte lane. On each request it forms the effective address from a base register and a signed 16-bit displacement. It checks that the access is naturally aligned for its size. For stores it moves the source bytes onto the right lanes and raises the matching lane enables.

Memory read data arrives in the cycle after a load request. The unit registers the access kind and the low address bits, and in that cycle it picks the addressed bytes from the returned word. It then widens them to 32 bits with sign or zero extension. Byte order is big-endian: byte offset 0 is data bits 31:24 and halfword offset 0 is bits 31:16. Any access that is not aligned raises a flag in the request cycle. Such an access never writes memory, and if it is a load it returns zero.

Top module: `ldst_unit`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals `base_addr` plus `disp` sign-extended to 32 bits, taken modulo 2^32.
- R2: `req_op` is encoded as 0 word load, 1 signed halfword load, 2 unsigned halfword load, 3 signed byte load, 4 unsigned byte load, 5 word store, 6 halfword store and 7 byte store. In the same cycle as a valid request, `misalign` is high when a word access has address bits 1:0 not equal to 00, or when a halfword access has address bit 0 set. It is never high for a byte access, and it is low when `req_valid` is low.
- R3: An aligned word store drives `mem_we` high, `mem_be` = 1111 and `mem_wdata` = `store_data`, all in the request cycle.
- R4: An aligned halfword store writes only `store_data[15:0]`. At address bits 1:0 = 00 it uses `mem_be` = 1100 with the data on bits 31:16. At 10 it uses `mem_be` = 0011 with the data on bits 15:0.
- R5: A byte store writes only `store_data[7:0]`, using a one-hot `mem_be`. Offset 0 gives 1000 with the data on bits 31:24, and offset 3 gives 0001 with the data on bits 7:0. The offsets in between follow the same pattern.
- R6: A misaligned store, any load and any idle cycle drive `mem_we` low and `mem_be` = 0000.
- R7: `rsp_valid` is high exactly in the cycle after a valid load request (ops 0 to 4), including a misaligned one. In that cycle `rsp_data` is formed from `mem_rdata`.
- R8: A word load returns all 32 bits of `mem_rdata`.
- R9: A halfword load returns the addressed 16 bits, sign-extended for op 1 and zero-extended for op 2.
- R10: A byte load returns the addressed 8 bits, sign-extended for op 3 and zero-extended for op 4.
- R11: When the load request was misaligned, `rsp_data` is zero in the response cycle.
- R12: During reset `rsp_valid` is low. The first cycle after reset carries no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Access kind (encoding in R2) |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Source register for stores |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| misalign | output | 1 | Alignment fault for the current request |
| mem_rdata | input | 32 | Read word returned the cycle after a load |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 32 | Extended load result |

## Verification
The only state in the block is the pending-load record: the access kind, the byte offset and the fault bit. If any of these is wrong, the damage shows in the single response cycle after the request. The result comes from the wrong lane or has the wrong upper bits, a faulted load returns nonzero data, or `rsp_valid` appears or goes missing. The store path has no state, so a lane-steering or enable error is visible on `mem_be` and `mem_wdata` in the request cycle itself. The reference model is compared on every clock, so either kind of fault is reported in the cycle it occurs.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_LH  = 3'd1,
    OP_LHU = 3'd2,
    OP_LB  = 3'd3,
    OP_LBU = 3'd4,
    OP_SW  = 3'd5,
    OP_SH  = 3'd6,
    OP_SB  = 3'd7
  } mem_op_e;

  // log2 of the access size in bytes
  function automatic logic [1:0] op_size(input mem_op_e op);
    case (op)
      OP_LW, OP_SW:         return 2'd2;
      OP_LH, OP_LHU, OP_SH: return 2'd1;
      default:              return 2'd0;
    endcase
  endfunction

  function automatic logic op_is_store(input mem_op_e op);
    return (op == OP_SW) || (op == OP_SH) || (op == OP_SB);
  endfunction

  function automatic logic op_is_signed(input mem_op_e op);
    return (op == OP_LH) || (op == OP_LB);
  endfunction

  function automatic logic is_misaligned(input mem_op_e op, input logic [1:0] lo);
    case (op_size(op))
      2'd2:    return lo != 2'b00;
      2'd1:    return lo[0];
      default: return 1'b0;
    endcase
  endfunction

  // big-endian lane mask: bit 3 is data bits 31:24 (byte offset 0)
  function automatic logic [LANES-1:0] lane_mask(input mem_op_e op, input logic [1:0] lo);
    case (op_size(op))
      2'd2:    return '1;
      2'd1:    return lo[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1000 >> lo;
    endcase
  endfunction
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mem_op_e           op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  disp,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - OFF_W;

  assign eff_addr = base_addr + {{EXT_W{disp[OFF_W-1]}}, disp};
  assign misalign = req_valid && is_misaligned(op, eff_addr[1:0]);

  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == OP_LB || op == OP_LBU || op == OP_SB)) |-> !misalign); // R2
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !misalign); // R2
endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mem_op_e           op,
  input  logic [1:0]        lo,
  input  logic              misalign,
  input  logic [WORD_W-1:0] store_data,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata
);
  logic do_write;

  assign do_write = req_valid && op_is_store(op) && !misalign;
  assign mem_we   = do_write;
  assign mem_be   = do_write ? lane_mask(op, lo) : '0;

  // each lane carries the source byte that would land there for this size;
  // the enables decide which lanes memory actually takes
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_byte;
    always_comb begin
      case (op_size(op))
        2'd2:    lane_byte = store_data[8*i +: 8];
        2'd1:    lane_byte = store_data[8*(i%2) +: 8];
        default: lane_byte = store_data[7:0];
      endcase
    end
    assign mem_wdata[8*i +: 8] = lane_byte;
  end

  AST_FAULT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == '0 && !mem_we)); // R6
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R4
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !op_is_store(op)) |-> (mem_be == '0)); // R6
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mem_op_e           op,
  input  logic [1:0]        lo,
  input  logic              misalign,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic              pend_q;
  mem_op_e           op_q;
  logic [1:0]        lo_q;
  logic              mis_q;
  logic              load_drop;
  logic [WORD_W-1:0] aligned_word;
  logic [WORD_W-1:0] extended;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      op_q   <= OP_LW;
      lo_q   <= 2'b00;
      mis_q  <= 1'b0;
    end else begin
      pend_q <= req_valid && !op_is_store(op);
      op_q   <= op;
      lo_q   <= lo;
      mis_q  <= misalign;
    end
  end

  // shift the addressed byte/halfword to the top of the word
  assign aligned_word = mem_rdata << {lo_q, 3'b000};

  always_comb begin
    case (op_size(op_q))
      2'd2:    extended = aligned_word;
      2'd1:    extended = {{16{op_is_signed(op_q) & aligned_word[31]}}, aligned_word[31:16]};
      default: extended = {{24{op_is_signed(op_q) & aligned_word[31]}}, aligned_word[31:24]};
    endcase
  end

  assign load_drop = pend_q && mis_q;
  assign rsp_valid = pend_q;
  assign rsp_data  = (pend_q && !mis_q) ? extended : '0;

  AST_DROP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_drop |-> (rsp_data == '0)); // R11
  AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !op_is_store(op))); // R7
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_LBU) |-> (rsp_data[31:8] == '0)); // R10
  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_LHU) |-> (rsp_data[31:16] == '0)); // R9
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  disp,
  input  logic [WORD_W-1:0] store_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              misalign,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  mem_op_e op;
  assign op = mem_op_e'(req_op);

  ldst_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .base_addr(base_addr), .disp(disp),
    .eff_addr(mem_addr), .misalign(misalign)
  );

  ldst_store_steer u_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .lo(mem_addr[1:0]), .misalign(misalign), .store_data(store_data),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  ldst_load_extract u_load (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .lo(mem_addr[1:0]), .misalign(misalign), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd5 && mem_addr[1:0] == 2'b00) |-> (mem_we && mem_be == 4'hF)); // R3
endmodule

// File: tb/test_ldst_unit.sv
module test_ldst_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // pending load seen by the reference
  bit pv = 0;
  int pop = 0;
  int plo = 0;
  bit pmis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_unit i_ldst_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base_addr(base_addr), .disp(disp), .store_data(store_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .misalign(misalign), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input int op);
    if (op == 0 || op == 5) return 4;
    if (op == 1 || op == 2 || op == 6) return 2;
    return 1;
  endfunction

  function automatic string st_tag(input int op, input bit mis);
    if (mis || op < 5) return "R6";
    if (op == 5) return "R3";
    if (op == 6) return "R4";
    return "R5";
  endfunction

  function automatic string ld_tag(input int op, input bit mis);
    if (mis) return "R11";
    if (op == 0) return "R8";
    if (op <= 2) return "R9";
    return "R10";
  endfunction

  // one bench cycle: drive, then compare every output with the model
  task automatic step(input bit v, input int op, input logic [31:0] b,
                      input logic [15:0] d, input logic [31:0] sd, input logic [31:0] rd);
    longint unsigned ea_l;
    logic [31:0] ea, exp_be, exp_wd, mask;
    int n, lo;
    bit mis, st;
    longint val;
    @(negedge clk);
    req_valid = v; req_op = op[2:0]; base_addr = b; disp = d;
    store_data = sd; mem_rdata = rd;
    #(CLK_PERIOD/4);
    ea_l = (longint'(b) + longint'($signed(d))) & 64'hFFFF_FFFF;
    ea = ea_l[31:0];
    n = nbytes(op);
    lo = int'(ea[1:0]);
    mis = v && ((lo % n) != 0);
    st = v && op >= 5;
    if (v) chk("R1 addr", mem_addr, ea);
    chk("R2 misalign", {31'd0, misalign}, {31'd0, mis});
    exp_be = '0; exp_wd = '0;
    if (st && !mis) begin
      for (int k = 0; k < n; k++) begin
        exp_be[3 - (lo + k)] = 1'b1;
        exp_wd = exp_wd | (((sd >> (8 * (n - 1 - k))) & 32'hFF) << (8 * (3 - (lo + k))));
      end
    end
    chk({st_tag(op, mis), " we"}, {31'd0, mem_we}, {31'd0, st && !mis});
    chk({st_tag(op, mis), " be"}, {28'd0, mem_be}, exp_be);
    mask = '0;
    for (int j = 0; j < 4; j++) if (exp_be[j]) mask[8*j +: 8] = 8'hFF;
    if (st && !mis) chk({st_tag(op, mis), " wdata"}, mem_wdata & mask, exp_wd);
    chk("R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, pv});
    if (pv) begin
      val = 0;
      if (!pmis) begin
        for (int k = 0; k < nbytes(pop); k++)
          val = (val << 8) | longint'((rd >> (8 * (3 - (plo + k)))) & 32'hFF);
        if ((pop == 1 || pop == 3) && val[8 * nbytes(pop) - 1])
          val = val - (longint'(1) << (8 * nbytes(pop)));
      end
      chk({ld_tag(pop, pmis), " rsp_data"}, rsp_data, val[31:0]);
    end
    pv = v && op < 5;
    pop = op;
    plo = lo;
    pmis = mis;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) begin
      @(negedge clk); #(CLK_PERIOD/4);
      chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      chk("R12 be in reset", {28'd0, mem_be}, 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);

    // word store, aligned and faulted (R3, R6, R2)
    step(1, 5, 32'h1000, 16'h0008, 32'hCAFE_F00D, 0);
    step(1, 5, 32'h1000, 16'h0001, 32'h1234_5678, 0);
    step(1, 5, 32'h1000, 16'h0002, 32'h1234_5678, 0);
    // halfword stores (R4)
    step(1, 6, 32'h2000, 16'h0000, 32'hAAAA_BEEF, 0);
    step(1, 6, 32'h2000, 16'h0002, 32'hAAAA_BEEF, 0);
    step(1, 6, 32'h2000, 16'h0003, 32'hAAAA_BEEF, 0);
    // byte stores at every offset (R5)
    for (int o = 0; o < 4; o++) step(1, 7, 32'h3000, 16'(o), 32'h1122_33C4, 0);
    // negative displacement and wraparound (R1)
    step(1, 5, 32'h0000_0010, 16'hFFF0, 32'h0, 0);
    step(1, 7, 32'h0000_0001, 16'hFFFC, 32'h55, 0);
    // loads: each result is checked in the following step (R7..R11)
    step(1, 0, 32'h4000, 16'h0004, 0, 0);
    step(1, 1, 32'h4000, 16'h0000, 0, 32'h8001_7FFF);
    step(1, 1, 32'h4000, 16'h0002, 0, 32'h8001_8002);
    step(1, 2, 32'h4000, 16'h0000, 0, 32'h8002_8002);
    step(1, 2, 32'h4000, 16'h0002, 0, 32'h8003_0000);
    step(1, 0, 32'h4000, 16'h0002, 0, 32'h8004_8004);
    step(1, 1, 32'h4000, 16'h0001, 0, 32'hDEAD_BEEF);
    for (int o = 0; o < 4; o++) step(1, 3, 32'h5000, 16'(o), 0, 32'hDEAD_BEEF);
    for (int o = 0; o < 4; o++) step(1, 4, 32'h5000, 16'(o), 0, 32'h80FF_7F01);
    step(0, 0, 0, 0, 0, 32'hF1F2_F3F4);
    step(0, 0, 0, 0, 0, 32'h0);

    // random traffic
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 4) != 0, $urandom_range(0, 7), $urandom(),
           16'($urandom()), $urandom(), $urandom());
    step(0, 0, 0, 0, 0, $urandom());

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule